// File: doc/BRIEF.md
# Pipelined Converter Stage-Code Corrector

This block sits behind the analog stages of an eleven-stage pipelined analog-to-digital converter and builds one 12-bit output word per clock from the raw decisions of those stages. Ten stages each deliver a three-level (1.5-bit) code and a final comparator stage delivers a single bit. The decisions belonging to one sample do not arrive together. Each later stage reports one clock after the stage before it, so on any given clock the input bus carries decisions from eleven different samples.

The block first forces any illegal stage code to a legal value. It then passes every stage's code through its own delay line, whose length depends on the stage's position, so that all eleven decisions of one sample meet in the same cycle. An adder then combines them with weights that overlap by one bit between neighbouring stages. Because of this overlap, a decision error of one step in a stage is cancelled by the following stage, and the sum stays correct. The result is registered together with a valid flag. It updates only when a sample completes and holds its value otherwise.

Top module: `pdec_corrector`

## Requirements
- R1: With stage k (k = 1 for the first, most significant stage) carried on `stage_codes[2k-1:2k-2]`, the output word equals the sum over k = 1..10 of code_k · 2^(11-k), plus the comparator bit. The largest possible value is 4093.
- R2: A stage code of binary 11 is weighted as if it were 10 (decimal 2).
- R3: A code of 1 in stage k with 0 in stage k+1 yields the same output as 0 in stage k with 2 in stage k+1.
- R4: For the sample whose first-stage code is taken on clock edge t, the code of stage k is taken on edge t+k-1 and the comparator bit on edge t+10.
- R5: `out_valid` is asserted, and `out_code` carries the new word, in the cycle after clock edge t+11, where t is the edge on which `in_valid` was high with the sample's first-stage code. Cycles with `in_valid` low produce no output.
- R6: With `in_valid` high on consecutive edges, `out_valid` is high on the same number of consecutive cycles. Gaps in `in_valid` appear as gaps of the same length at the output.
- R7: While `rst` is high on a clock edge, `out_valid` and `out_code` are cleared by that edge, and every sample whose first-stage edge falls in the eleven edges before a reset edge, or on it, is dropped.
- R8: `out_code` keeps its previous value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new sample's first-stage code is present on this edge |
| stage_codes | input | 20 | Ten 2-bit stage codes; stage k at bits [2k-1:2k-2] |
| cmp_bit | input | 1 | Decision of the final comparator stage |
| out_valid | output | 1 | `out_code` holds a newly completed sample |
| out_code | output | 12 | Corrected output word |

## Verification
Single-hot patterns light one stage at a time, which separates the weight of each stage from that of its neighbours. Samples with every code at 1 or at 2 test the overlap of carries. Samples that alternate between the full-scale and zero patterns, driven back to back, fail as soon as any stage's delay is off by one cycle, because a misaligned code then comes from the opposite pattern. Pairs of codes that differ only by where a redundant step is placed must give equal words. Random streams with illegal codes, with gaps in `in_valid`, and with a reset in the middle of a stream test code folding, the valid flag, the hold behaviour and the flushing of samples in flight.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

   // one 1.5-bit stage decision: legal values 0, 1, 2
   typedef logic [1:0] stage_code_t;

   localparam stage_code_t CODE_TOP = 2'd2;

   // map the unused encoding onto the highest legal level
   function automatic stage_code_t fold_code(input stage_code_t raw);
      return (raw > CODE_TOP) ? CODE_TOP : raw;
   endfunction

endpackage

// File: rtl/pdec_code_fold.sv
module pdec_code_fold
   import pdec_pkg::*;
(
   input  stage_code_t raw_code,
   output stage_code_t legal_code
);

   assign legal_code = fold_code(raw_code);

endmodule

// File: rtl/pdec_skew_line.sv
module pdec_skew_line #(
   parameter int W     = 2,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_width
      $error("pdec_skew_line: W must be at least 1");
   end
   if (DEPTH < 0) begin : g_bad_depth
      $error("pdec_skew_line: DEPTH must not be negative");
   end

   if (DEPTH == 0) begin : g_wire
      assign q = d;
   end else begin : g_regs
      logic [W-1:0] tap [DEPTH];

      always_ff @(posedge clk) begin
         if (rst) begin
            for (int j = 0; j < DEPTH; j++) tap[j] <= '0;
         end else begin
            tap[0] <= d;
            for (int j = 1; j < DEPTH; j++) tap[j] <= tap[j-1];
         end
      end

      assign q = tap[DEPTH-1];
   end

endmodule

// File: rtl/pdec_merge.sv
module pdec_merge
   import pdec_pkg::*;
#(
   parameter int NSTG  = 10,
   parameter int OUT_W = NSTG + 2
) (
   input  stage_code_t      codes [NSTG],
   input  logic             lsb_bit,
   output logic [OUT_W-1:0] sum
);

   // stage index i (0 = first stage) carries weight 2^(NSTG-i):
   // neighbouring weights overlap by one bit
   always_comb begin
      logic [OUT_W-1:0] acc;
      acc = OUT_W'(lsb_bit);
      for (int i = 0; i < NSTG; i++) begin
         acc = acc + (OUT_W'(codes[i]) << (NSTG - i));
      end
      sum = acc;
   end

endmodule

// File: rtl/pdec_corrector.sv
module pdec_corrector
   import pdec_pkg::*;
#(
   parameter int NSTG  = 10,
   parameter int OUT_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [2*NSTG-1:0] stage_codes,
   input  logic              cmp_bit,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_code
);

   localparam int LAT      = NSTG + 1;
   localparam int CODE_MAX = (1 << OUT_W) - 3;
   localparam int CNT_W    = $clog2(LAT + 3);

   if (NSTG < 2) begin : g_bad_stages
      $error("pdec_corrector: NSTG must be at least 2");
   end
   if (OUT_W != NSTG + 2) begin : g_bad_out_w
      $error("pdec_corrector: OUT_W must equal NSTG + 2");
   end

   stage_code_t aligned [NSTG];
   logic        cmp_aligned;
   logic        vld_aligned;
   logic [OUT_W-1:0] merged;

   // per-stage folding and alignment; stage g+1 arrives g clocks late
   for (genvar g = 0; g < NSTG; g++) begin : g_stage
      stage_code_t folded;

      pdec_code_fold u_fold (
         .raw_code   (stage_codes[2*g +: 2]),
         .legal_code (folded)
      );

      // R2
      fold_range_chk: assert property (@(posedge clk) disable iff (rst)
         folded != 2'b11);

      pdec_skew_line #(.W(2), .DEPTH(NSTG + 1 - g)) u_skew (
         .clk (clk),
         .rst (rst),
         .d   (folded),
         .q   (aligned[g])
      );
   end

   pdec_skew_line #(.W(1), .DEPTH(1)) u_cmp_skew (
      .clk (clk),
      .rst (rst),
      .d   (cmp_bit),
      .q   (cmp_aligned)
   );

   pdec_skew_line #(.W(1), .DEPTH(LAT)) u_vld_skew (
      .clk (clk),
      .rst (rst),
      .d   (in_valid),
      .q   (vld_aligned)
   );

   pdec_merge #(.NSTG(NSTG), .OUT_W(OUT_W)) u_merge (
      .codes   (aligned),
      .lsb_bit (cmp_aligned),
      .sum     (merged)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_code  <= '0;
      end else begin
         out_valid <= vld_aligned;
         if (vld_aligned) out_code <= merged;
      end
   end

   // ---------------- checks ----------------
   logic             rst_d_q;
   logic [CNT_W-1:0] inflight_q;

   always_ff @(posedge clk) begin
      rst_d_q <= rst;
      if (rst) inflight_q <= '0;
      else     inflight_q <= inflight_q + CNT_W'(in_valid) - CNT_W'(out_valid);
   end

   // R7
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      rst_d_q |-> (!out_valid && out_code == '0));

   // R1
   code_range_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (int'(out_code) <= CODE_MAX));

   // R6
   inflight_bound_chk: assert property (@(posedge clk) disable iff (rst)
      int'(inflight_q) <= LAT + 1);

   // R5
   no_orphan_out_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> inflight_q != '0);

   // R8
   hold_code_chk: assert property (@(posedge clk) disable iff (rst)
      (!out_valid && !rst_d_q) |-> $stable(out_code));

endmodule

// File: tb/pdec_corrector_bench.sv
module pdec_corrector_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NSTG  = 10;
   localparam int OUT_W = 12;
   localparam int NS    = 300;
   localparam int LATE  = 12;

   logic              clk = 1'b0;
   logic              rst;
   logic              in_valid;
   logic [2*NSTG-1:0] stage_codes;
   logic              cmp_bit;
   logic              out_valid;
   logic [OUT_W-1:0]  out_code;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [2*NSTG-1:0] sc [NS];
   logic              cb [NS];
   logic              vl [NS];
   logic              rs [NS];
   string             seg_tag [NS];

   always #(CLK_PERIOD/2) clk = ~clk;

   pdec_corrector #(.NSTG(NSTG), .OUT_W(OUT_W)) u_pdec_corrector (
      .clk         (clk),
      .rst         (rst),
      .in_valid    (in_valid),
      .stage_codes (stage_codes),
      .cmp_bit     (cmp_bit),
      .out_valid   (out_valid),
      .out_code    (out_code)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int model(input int s);
      int acc;
      acc = int'(cb[s]);
      for (int k = 0; k < NSTG; k++) begin
         int c;
         c = int'(sc[s][2*k +: 2]);
         if (c == 3) c = 2;               // R2 folding
         acc += c << (NSTG - k);          // R1 weights
      end
      return acc;
   endfunction

   function automatic logic [2*NSTG-1:0] rnd_legal();
      logic [2*NSTG-1:0] v;
      for (int k = 0; k < NSTG; k++) v[2*k +: 2] = 2'($urandom_range(2, 0));
      return v;
   endfunction

   function automatic bit rst_in(input int lo, input int hi);
      for (int e = lo; e <= hi; e++)
         if (e >= 0 && e < NS && rs[e]) return 1'b1;
      return 1'b0;
   endfunction

   initial begin
      int p;
      rst = 1'b1; in_valid = 1'b0; stage_codes = '0; cmp_bit = 1'b0;
      for (int i = 0; i < NS; i++) begin
         sc[i] = '0; cb[i] = 1'b0; vl[i] = 1'b0; rs[i] = 1'b0; seg_tag[i] = "R5";
      end
      p = 0;
      // R7 power-on reset
      for (int i = 0; i < 3; i++) begin rs[p] = 1'b1; seg_tag[p] = "R7"; p++; end
      // R1 one stage at a time, then comparator alone
      for (int j = 0; j <= NSTG; j++) begin
         if (j < NSTG) sc[p][2*j +: 2] = 2'd2; else cb[p] = 1'b1;
         vl[p] = 1'b1; seg_tag[p] = "R1"; p++;
      end
      // R1 all ones, all twos, zero
      for (int i = 0; i < 4; i++) begin
         sc[p] = {NSTG{2'b01}}; cb[p] = 1'(i); vl[p] = 1'b1; seg_tag[p] = "R1"; p++;
      end
      for (int i = 0; i < 3; i++) begin
         sc[p] = {NSTG{2'b10}}; cb[p] = 1'b1; vl[p] = 1'b1; seg_tag[p] = "R1"; p++;
      end
      vl[p] = 1'b1; seg_tag[p] = "R1"; p++;
      // R2 illegal codes
      sc[p] = {NSTG{2'b11}}; cb[p] = 1'b1; vl[p] = 1'b1; seg_tag[p] = "R2"; p++;
      for (int i = 0; i < 30; i++) begin
         sc[p] = 20'($urandom); cb[p] = 1'($urandom); vl[p] = 1'b1; seg_tag[p] = "R2"; p++;
      end
      // R3 redundant placements
      for (int k = 0; k < NSTG - 1; k++) begin
         sc[p][2*k +: 2] = 2'd1; vl[p] = 1'b1; seg_tag[p] = "R3"; p++;
         sc[p][2*(k+1) +: 2] = 2'd2; vl[p] = 1'b1; seg_tag[p] = "R3"; p++;
      end
      // R4 alternating full-scale and zero
      for (int i = 0; i < 20; i++) begin
         if (i % 2 == 0) begin sc[p] = {NSTG{2'b10}}; cb[p] = 1'b1; end
         vl[p] = 1'b1; seg_tag[p] = "R4"; p++;
      end
      // R6 gaps in valid
      for (int i = 0; i < 60; i++) begin
         sc[p] = rnd_legal(); cb[p] = 1'($urandom);
         vl[p] = ($urandom_range(2, 0) != 0); seg_tag[p] = "R6"; p++;
      end
      // R7 reset in mid-stream
      for (int i = 0; i < 20; i++) begin
         sc[p] = rnd_legal(); cb[p] = 1'($urandom); vl[p] = 1'b1;
         rs[p] = (i == 8 || i == 9); seg_tag[p] = "R7"; p++;
      end
      // R1 long random stream
      for (int i = 0; i < 100; i++) begin
         sc[p] = rnd_legal(); cb[p] = 1'($urandom); vl[p] = 1'b1; seg_tag[p] = "R1"; p++;
      end

      begin
         int exp_code;
         exp_code = 0;
         for (int cyc = 0; cyc < NS + LATE + 2; cyc++) begin
            @(negedge clk);
            if (cyc >= 1) begin
               int s;
               bit ev;
               string tg;
               s = cyc - LATE;
               if (cyc - 1 < NS && rs[cyc-1]) begin
                  exp_code = 0;
                  check("R7", "reset valid", int'(out_valid), 0);
                  check("R7", "reset code", int'(out_code), 0);
               end else begin
                  ev = (s >= 0 && s < NS) ? (vl[s] && !rst_in(s, s + LATE - 1)) : 1'b0;
                  if (ev) exp_code = model(s);
                  tg = (s >= 0 && s < NS && rst_in(s, s + LATE - 1)) ? "R7" :
                       (s >= 0 && s < NS && seg_tag[s] == "R6") ? "R6" : "R5";
                  check(tg, "valid", int'(out_valid), int'(ev));
                  if (ev) check(seg_tag[s], "code", int'(out_code), exp_code);
                  else    check("R8", "held code", int'(out_code), exp_code);
               end
            end
            // drive the skewed decisions of cycle cyc (R4)
            rst      = (cyc < NS) ? rs[cyc] : 1'b0;
            in_valid = (cyc < NS) ? vl[cyc] : 1'b0;
            for (int k = 0; k < NSTG; k++) begin
               int idx;
               idx = cyc - k;
               stage_codes[2*k +: 2] = (idx >= 0 && idx < NS) ? sc[idx][2*k +: 2] : 2'd0;
            end
            cmp_bit = (cyc - NSTG >= 0 && cyc - NSTG < NS) ? cb[cyc - NSTG] : 1'b0;
         end
      end
      // R3 direct pairwise comparison of the model
      for (int k = 0; k < NSTG - 1; k++) begin
         logic [2*NSTG-1:0] a, b;
         a = '0; b = '0;
         a[2*k +: 2] = 2'd1; b[2*(k+1) +: 2] = 2'd2;
         check("R3", "pair weights", int'(a[2*k +: 2]) << (NSTG - k),
               int'(b[2*(k+1) +: 2]) << (NSTG - k - 1));
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule